// File: doc/BRIEF.md
# Per-CPU Interrupt Level Slice

This block is the processor-side slice of an interrupt controller. It holds one 32-bit pending word for a single CPU. That word carries four kinds of request. Software raises and lowers soft interrupts by writing to it. A broadcast line carries the level-15 request, a local timer line carries the timer request, and the bottom of the word shows a copy of the hardware levels that the master controller currently steers to this CPU.

Every cycle the slice folds these sources into a 16-bit processor interrupt level (PIL) vector. Bit n of that vector requests level n, and level 0 never exists. The vector is registered. A priority encoder turns it into the number of the highest requested level.

Software reaches the word through a request channel of 32-bit single-cycle accesses. `req_ready` is held high, so the slice never pushes back: every cycle in which `req_valid` is high completes one access. A read returns its data on `rsp_valid`/`rsp_data` exactly one cycle after the request. The response channel has no ready signal, so the requester must take it in that cycle.

Top module: `cpu_irq_slice`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), the pending word, `pil_vec`, `pil_top` and `rsp_valid` are all zero.
- R2: A read request (`req_write`=0) at word offset 0 returns the pending word as it stood in the request cycle. It comes back on `rsp_data` with `rsp_valid` high in the next cycle. Reads at offsets 1, 2 and 3 return zero. `rsp_valid` is low in every cycle that does not follow a read request.
- R3: A write at word offset 2 sets pending bits. The write data is first ANDed with a mask of bits 31..17.
- R4: A write at word offset 1 clears pending bits. The write data is first ANDed with a mask of bits 31..17 plus bit 15. Bits 14..0 (other than 15) are not affected.
- R5: Pending bit 14 follows `timer_in` and pending bit 15 follows `bcast15_in`. A rising edge on the line sets the bit and a falling edge clears it. After a clear write, bit 15 stays zero, even with the line still high, until the line rises again. In a cycle where both happen, the line edge wins over a clear write.
- R6: Soft bit n of the pending word (n = 17..31) drives PIL bit n-16, so bit 17 gives level 1 and bit 31 gives level 15.
- R7: While `master_off` is high, pending bits 15 and 14 do not reach `pil_vec`. Soft bits and `route_lvl` still do.
- R8: `route_lvl` bits 15..1 are ORed into `pil_vec`. Bits 13..1 of `route_lvl` are also copied into pending bits 13..1 for reads. `route_lvl` bit 0 is ignored.
- R9: `pil_vec` bit 0 and pending bits 16 and 0 are always zero.
- R10: `pil_vec` is registered. A change in any input or in the pending word shows on `pil_vec` at the first rising clock edge after the change, and not before that edge.
- R11: `pil_top` is the index of the highest set bit of `pil_vec`, or 0 when `pil_vec` is zero.
- R12: `req_ready` is always high. Writes at offsets 0 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_ready | output | 1 | Always high; the slice never stalls |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_data | output | 32 | Read data |
| timer_in | input | 1 | Local timer request line |
| bcast15_in | input | 1 | Level-15 broadcast line |
| route_lvl | input | 16 | Hardware levels steered to this CPU by the master |
| master_off | input | 1 | Master-disable flag from the master controller |
| pil_vec | output | 16 | Registered PIL vector, bit n = level n |
| pil_top | output | 4 | Highest active level, 0 if none |

## Verification
The assertions assume some things about the inputs. The request fields are known whenever `req_valid` is high. The request lines, `timer_in`, `bcast15_in`, `route_lvl` and `master_off` are all low while reset is asserted. The line-edge checks assume that each line is sampled once per cycle, with no glitches between edges. The bench holds every input at zero during reset and changes inputs only on falling clock edges, so each value is stable for a full cycle around the sampling edge. It also issues at most one access per cycle, so a set and a clear never meet in the same cycle.

// File: rtl/cis_pkg.sv
package cis_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_LVL   = 16;
  localparam int LVL_W     = $clog2(NUM_LVL);
  localparam int SOFT_LSB  = NUM_LVL + 1;
  localparam int SOFT_SHR  = NUM_LVL;
  localparam int TIMER_POS = NUM_LVL - 2;
  localparam int BC15_POS  = NUM_LVL - 1;
  localparam int DISP_MSB  = NUM_LVL - 3;

  localparam int OFF_PEND  = 0;
  localparam int OFF_CLR   = 1;
  localparam int OFF_SET   = 2;

  localparam logic [WORD_W-1:0] SOFT_MASK =
    {{(WORD_W-SOFT_LSB){1'b1}}, {SOFT_LSB{1'b0}}};
  localparam logic [WORD_W-1:0] CLR_MASK  =
    SOFT_MASK | (WORD_W'(1) << BC15_POS);

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CLR  = 2'd1,
    ACC_SET  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/cis_bus_if.sv
module cis_bus_if
  import cis_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] pend_q,
  output acc_kind_e         acc_kind,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);

  logic is_rd;
  assign is_rd = req_valid && !req_write;

  always_comb begin
    acc_kind = ACC_NONE;
    if (req_valid && req_write) begin
      if (req_addr == ADDR_W'(OFF_CLR))      acc_kind = ACC_CLR;
      else if (req_addr == ADDR_W'(OFF_SET)) acc_kind = ACC_SET;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= is_rd;
      if (is_rd)
        rsp_data <= (req_addr == ADDR_W'(OFF_PEND)) ? pend_q : '0;
      else
        rsp_data <= '0;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(is_rd)); // R2
  AST_RSP_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && req_addr != ADDR_W'(OFF_PEND)) |=> (rsp_data == '0)); // R2

endmodule

// File: rtl/cis_pend_reg.sv
module cis_pend_reg
  import cis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         acc_kind,
  input  logic [WORD_W-1:0] wdata,
  input  logic              timer_i,
  input  logic              bc15_i,
  input  logic [DISP_MSB:1] disp_i,
  output logic [WORD_W-1:0] pend_nx,
  output logic [WORD_W-1:0] pend_q
);

  logic timer_d1, bc15_d1;
  logic [WORD_W-1:0] set_bits, clr_bits;
  logic [WORD_W-1:0] soft_nx;
  logic bc15_nx, timer_nx;

  assign set_bits = (acc_kind == ACC_SET) ? (wdata & SOFT_MASK) : '0;
  assign clr_bits = (acc_kind == ACC_CLR) ? (wdata & CLR_MASK)  : '0;
  assign soft_nx  = ((pend_q & ~clr_bits) | set_bits) & SOFT_MASK;

  always_comb begin
    if (bc15_i && !bc15_d1)       bc15_nx = 1'b1;
    else if (!bc15_i && bc15_d1)  bc15_nx = 1'b0;
    else if (clr_bits[BC15_POS])  bc15_nx = 1'b0;
    else                          bc15_nx = pend_q[BC15_POS];
  end

  always_comb begin
    if (timer_i && !timer_d1)       timer_nx = 1'b1;
    else if (!timer_i && timer_d1)  timer_nx = 1'b0;
    else                            timer_nx = pend_q[TIMER_POS];
  end

  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b >= SOFT_LSB) begin : g_soft
        assign pend_nx[b] = soft_nx[b];
      end else if (b == BC15_POS) begin : g_bc
        assign pend_nx[b] = bc15_nx;
      end else if (b == TIMER_POS) begin : g_tmr
        assign pend_nx[b] = timer_nx;
      end else if (b >= 1 && b <= DISP_MSB) begin : g_disp
        assign pend_nx[b] = disp_i[b];
      end else begin : g_zero
        assign pend_nx[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      timer_d1 <= 1'b0;
      bc15_d1  <= 1'b0;
    end else begin
      pend_q   <= pend_nx;
      timer_d1 <= timer_i;
      bc15_d1  <= bc15_i;
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_SET) |=> ((pend_q & $past(wdata & SOFT_MASK)) == $past(wdata & SOFT_MASK))); // R3
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == ACC_CLR) |=> ((pend_q & $past(wdata & SOFT_MASK)) == '0)); // R4
  AST_TIMER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_i) |=> pend_q[TIMER_POS]); // R5
  AST_TIMER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timer_i) |=> !pend_q[TIMER_POS]); // R5
  AST_BC15_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bc15_i) |=> pend_q[BC15_POS]); // R5
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[SOFT_LSB-1] == 1'b0) && (pend_q[0] == 1'b0)); // R9

endmodule

// File: rtl/cis_pil_merge.sv
module cis_pil_merge
  import cis_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  pend_nx,
  input  logic [NUM_LVL-1:0] route_i,
  input  logic               mdis_i,
  output logic [NUM_LVL-1:0] pil_q
);

  logic [NUM_LVL-1:0] soft_lv, hard_lv, pil_nx;
  logic               unused_route0;

  assign unused_route0 = route_i[0];
  assign soft_lv = NUM_LVL'(pend_nx >> SOFT_SHR);

  generate
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      if (l == TIMER_POS || l == BC15_POS) begin : g_gated
        assign hard_lv[l] = pend_nx[l] && !mdis_i;
      end else begin : g_none
        assign hard_lv[l] = 1'b0;
      end
      if (l == 0) begin : g_l0
        assign pil_nx[l] = 1'b0;
      end else begin : g_ln
        assign pil_nx[l] = soft_lv[l] | hard_lv[l] | route_i[l];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pil_q <= '0;
    else        pil_q <= pil_nx;
  end

  AST_PIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pend_nx) && $stable(route_i) && $stable(mdis_i)) |=> $stable(pil_q)); // R10

endmodule

// File: rtl/cis_prio_enc.sv
module cis_prio_enc
  import cis_pkg::*;
(
  input  logic [NUM_LVL-1:0] vec_i,
  output logic [LVL_W-1:0]   top_o
);

  always_comb begin
    top_o = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (vec_i[i]) top_o = LVL_W'(i);
    end
  end

endmodule

// File: rtl/cpu_irq_slice.sv
module cpu_irq_slice
  import cis_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data,
  input  logic               timer_in,
  input  logic               bcast15_in,
  input  logic [NUM_LVL-1:0] route_lvl,
  input  logic               master_off,
  output logic [NUM_LVL-1:0] pil_vec,
  output logic [LVL_W-1:0]   pil_top
);

  acc_kind_e         acc_kind;
  logic [WORD_W-1:0] pend_q, pend_nx;

  assign req_ready = 1'b1;

  cis_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .pend_q    (pend_q),
    .acc_kind  (acc_kind),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  cis_pend_reg u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_kind (acc_kind),
    .wdata    (req_wdata),
    .timer_i  (timer_in),
    .bc15_i   (bcast15_in),
    .disp_i   (route_lvl[DISP_MSB:1]),
    .pend_nx  (pend_nx),
    .pend_q   (pend_q)
  );

  cis_pil_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_nx (pend_nx),
    .route_i (route_lvl),
    .mdis_i  (master_off),
    .pil_q   (pil_vec)
  );

  cis_prio_enc u_enc (
    .vec_i (pil_vec),
    .top_o (pil_top)
  );

  AST_MDIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_off && !route_lvl[TIMER_POS] && !pend_nx[TIMER_POS+SOFT_SHR])
      |=> !pil_vec[TIMER_POS]); // R7
  AST_SOFT_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[SOFT_LSB] |-> pil_vec[1]); // R6
  AST_TOP_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pil_top == '0) || pil_vec[pil_top]); // R11
  AST_TOP_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (pil_vec >> pil_top) <= NUM_LVL'(1)); // R11

endmodule

// File: tb/sim_cpu_irq_slice.sv
`timescale 1ns/1ps
module sim_cpu_irq_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        timer_in = 1'b0, bcast15_in = 1'b0, master_off = 1'b0;
  logic [15:0] route_lvl = '0;
  logic [15:0] pil_vec;
  logic [3:0]  pil_top;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpu_irq_slice u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .timer_in(timer_in),
    .bcast15_in(bcast15_in), .route_lvl(route_lvl), .master_off(master_off),
    .pil_vec(pil_vec), .pil_top(pil_top)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [1:0]  op;     // 0 idle, 1 write, 2 read
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic        tmr;
    logic        l15;
    logic        mdis;
    logic [15:0] route;
    logic [15:0] epil;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [0:NV-1] = '{
    '{"R2", 2'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h0,    32'h0},
    '{"R3", 2'd1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 16'h0,    16'hFFFE, 32'h0},
    '{"R6", 2'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'hFFFE, 32'hFFFE_0000},
    '{"R4", 2'd1, 2'd1, 32'hAAAA_FFFF, 1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h0},
    '{"R4", 2'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h5554_0000},
    '{"R2", 2'd2, 2'd1, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h0},
    '{"R2", 2'd2, 2'd2, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h0},
    '{"R2", 2'd2, 2'd3, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h0},
    '{"R12",2'd1, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h0},
    '{"R12",2'd1, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h0},
    '{"R12",2'd2, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h5554, 32'h5554_0000},
    '{"R4", 2'd1, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 16'h0,    16'h0,    32'h0},
    '{"R5", 2'd0, 2'd0, 32'h0,         1'b1, 1'b0, 1'b0, 16'h0,    16'h4000, 32'h0},
    '{"R5", 2'd0, 2'd0, 32'h0,         1'b1, 1'b1, 1'b0, 16'h0,    16'hC000, 32'h0},
    '{"R7", 2'd0, 2'd0, 32'h0,         1'b1, 1'b1, 1'b1, 16'h0,    16'h0,    32'h0},
    '{"R5", 2'd2, 2'd0, 32'h0,         1'b1, 1'b1, 1'b1, 16'h0,    16'h0,    32'h0000_C000},
    '{"R7", 2'd1, 2'd2, 32'h4000_0000, 1'b1, 1'b1, 1'b1, 16'h0,    16'h4000, 32'h0},
    '{"R5", 2'd1, 2'd1, 32'h4000_8000, 1'b1, 1'b1, 1'b0, 16'h0,    16'h4000, 32'h0},
    '{"R5", 2'd2, 2'd0, 32'h0,         1'b1, 1'b1, 1'b0, 16'h0,    16'h4000, 32'h0000_4000},
    '{"R5", 2'd0, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h0,    32'h0},
    '{"R5", 2'd0, 2'd0, 32'h0,         1'b0, 1'b1, 1'b0, 16'h0,    16'h8000, 32'h0},
    '{"R8", 2'd0, 2'd0, 32'h0,         1'b0, 1'b1, 1'b0, 16'h0025, 16'h8024, 32'h0},
    '{"R8", 2'd2, 2'd0, 32'h0,         1'b0, 1'b1, 1'b0, 16'h0025, 16'h8024, 32'h0000_8024},
    '{"R8", 2'd0, 2'd0, 32'h0,         1'b0, 1'b1, 1'b0, 16'h4000, 16'hC000, 32'h0},
    '{"R7", 2'd0, 2'd0, 32'h0,         1'b0, 1'b1, 1'b1, 16'h4000, 16'h4000, 32'h0},
    '{"R5", 2'd0, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 16'h0,    16'h0,    32'h0}
  };

  function automatic logic [3:0] top_of(input logic [15:0] v);
    logic [3:0] r = 4'd0;
    for (int i = 15; i >= 1; i--) begin
      if (v[i]) begin r = 4'(i); break; end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pil", {16'h0, pil_vec}, 32'h0);
    chk("R1 top", {28'h0, pil_top}, 32'h0);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready", {31'h0, req_ready}, 32'h1);

    // vector table
    for (int k = 0; k < NV; k++) begin
      req_valid  = (TBL[k].op != 2'd0);
      req_write  = (TBL[k].op == 2'd1);
      req_addr   = TBL[k].addr;
      req_wdata  = TBL[k].wdata;
      timer_in   = TBL[k].tmr;
      bcast15_in = TBL[k].l15;
      master_off = TBL[k].mdis;
      route_lvl  = TBL[k].route;
      @(negedge clk);
      chk({string'(TBL[k].tag), " pil"}, {16'h0, pil_vec}, {16'h0, TBL[k].epil});
      chk("R11 top", {28'h0, pil_top}, {28'h0, top_of(TBL[k].epil)});
      chk("R2 rsp_valid", {31'h0, rsp_valid}, {31'h0, TBL[k].op == 2'd2});
      if (TBL[k].op == 2'd2)
        chk({string'(TBL[k].tag), " rdata"}, rsp_data, TBL[k].erd);
    end
    req_valid = 1'b0;

    // R10: latency, drive at negedge, check before and after the next edge
    timer_in = 1'b1;
    #1;
    chk("R10 before edge", {16'h0, pil_vec}, 32'h0);
    @(negedge clk);
    chk("R10 after edge", {16'h0, pil_vec}, 32'h0000_4000);
    timer_in = 1'b0;
    @(negedge clk);

    // R9: route everything, bit 0 stays low
    route_lvl = 16'hFFFF;
    @(negedge clk);
    chk("R9 pil", {16'h0, pil_vec}, 32'h0000_FFFE);
    chk("R11 top15", {28'h0, pil_top}, 32'hF);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rdata", rsp_data, 32'h0000_3FFE);
    route_lvl = 16'h0;

    // R6: single soft bit 17 gives level 1
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd2; req_wdata = 32'h0002_0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 lvl1", {16'h0, pil_vec}, 32'h0000_0002);
    chk("R11 top1", {28'h0, pil_top}, 32'h1);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async pil", {16'h0, pil_vec}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 pend after reset", rsp_data, 32'h0);

    finish_run();
  end
endmodule